// File: doc/BRIEF.md
# Direct-Mapped Translation Cache

This block keeps recently used virtual-to-physical page translations close to the pipeline. It holds one direct-mapped table per side: instruction fetches use one table and data accesses use the other, and a side-select input on each request picks the table. Each table has 64 entries of 4 KB pages. A request presents a 32-bit virtual address. The entry at index `vaddr[17:12]` of the chosen table is compared against the full virtual page number `vaddr[31:12]`. On a match the block answers with the stored physical page joined to the untranslated 12-bit offset.

When the lookup does not match, the block holds the requester off and issues a request to an external slow translation path. That path returns a physical page and three flags: copy-on-write, device-backed and fault. An ordinary result is written into the cache and forwarded to the requester. A device-backed result or a fault is forwarded to the requester but not kept in the cache. A write that finds an entry flagged copy-on-write is treated as a miss, so the slow path runs again. A single-cycle invalidate-all input empties both tables. Two free-running counters report the number of accepted lookups and the number of slow-path requests.

Top module: `translation_cache`

## Requirements
- R1: After reset every entry of both tables is invalid, both counters read 0, `reqReady` is 1, and `rspValid` and `walkReqValid` are 0.
- R2: `reqReady` is high only while no request is in flight. Each accepted request (`reqValid && reqReady` at a clock edge) yields exactly one single-cycle `rspValid` pulse. For a hit, the pulse comes in the second cycle after the accepting edge.
- R3: A hit occurs when the entry at index `vaddr[17:12]` of the table selected by `reqSide` (0 = instruction, 1 = data) is valid and its stored page equals `vaddr[31:12]`. The response then has `rspHit`=1, `rspPaddr` = {stored physical page, `vaddr[11:0]`}, and no slow-path request is made.
- R4: On a miss, `walkReqValid` rises in the second cycle after acceptance. It stays high, with stable `walkReqVaddr`, `walkReqWrite` and `walkReqSide`, until the cycle in which `walkRspValid` is seen. The response that follows has `rspHit`=0 and `rspPaddr` = {`walkRspPage`, `vaddr[11:0]`}.
- R5: A slow-path result with both `walkRspDevice` and `walkRspFault` low is installed together with its copy-on-write flag. A later read of the same page on the same side then hits with that physical page.
- R6: The two tables are independent. An entry installed on one side does not produce a hit for the same address on the other side.
- R7: Two pages that share index bits `[17:12]` replace each other. After the second is installed, the first misses.
- R8: A write that matches an entry flagged copy-on-write is handled as a miss and goes to the slow path. A read of the same entry still hits.
- R9: A device-backed result (`walkRspDevice`=1) is returned with `rspDevice`=1 and is not installed. The next access to that page misses.
- R10: A faulting result (`walkRspFault`=1) is returned with `rspFault`=1 and `rspPaddr`=0 and is not installed.
- R11: A one-cycle pulse on `invAll` invalidates every entry of both tables. Every access accepted afterwards misses until its page is installed again.
- R12: `lookupCount` increases by one for each accepted request. `missCount` increases by one for each slow-path request, so it never exceeds `lookupCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| invAll | input | 1 | Invalidate every entry of both tables |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Request is a write |
| reqSide | input | 1 | Table select: 0 instruction, 1 data |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 32 | Translated physical address |
| rspHit | output | 1 | Response came from the cache |
| rspDevice | output | 1 | Response is device-backed |
| rspFault | output | 1 | Slow path reported no mapping |
| walkReqValid | output | 1 | Slow-path request outstanding |
| walkReqVaddr | output | 32 | Address sent to the slow path |
| walkReqWrite | output | 1 | Access type sent to the slow path |
| walkReqSide | output | 1 | Table select sent to the slow path |
| walkRspValid | input | 1 | Slow-path result strobe |
| walkRspPage | input | 20 | Physical page number from the slow path |
| walkRspCow | input | 1 | Result is copy-on-write |
| walkRspDevice | input | 1 | Result is device-backed |
| walkRspFault | input | 1 | Slow path found no mapping |
| lookupCount | output | 32 | Accepted lookups |
| missCount | output | 32 | Slow-path requests issued |

## Verification
A corrupt tag, page or valid bit inside the tables is visible at the ports on the next access that maps to that index. It shows up as a hit where a miss was due, as a miss where a hit was due, or as a wrong `rspPaddr`, within two cycles of acceptance. Lost or extra state in the controller shows up as a missing or doubled `rspValid`, as `reqReady` stuck low, or as counters that drift from the count of accepted requests and issued walks. The bench keeps its own model of both tables and compares every response and both counters after each access. Random traffic is drawn from a small page pool, so hits, conflicts and copy-on-write writes recur often.

// File: rtl/tcache_pkg.sv
package tcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WALK = 2'd2
  } tcState_e;

  typedef struct packed {
    logic latchReq;
    logic loadHit;
    logic loadWalk;
    logic install;
    logic incMiss;
  } tcStrobe_t;

endpackage

// File: rtl/tcache_ctrl.sv
module tcache_ctrl
  import tcache_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      hitRaw,
  input  logic      cowBlock,
  input  logic      walkRspValid,
  input  logic      walkRspDevice,
  input  logic      walkRspFault,
  output logic      reqReady,
  output logic      walkReqValid,
  output tcStrobe_t strobe
);

  tcState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD       = stateQ;
    strobe       = '0;
    reqReady     = 1'b0;
    walkReqValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateD          = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hitRaw && !cowBlock) begin
          strobe.loadHit = 1'b1;
          stateD         = ST_IDLE;
        end else begin
          strobe.incMiss = 1'b1;
          stateD         = ST_WALK;
        end
      end
      ST_WALK: begin
        walkReqValid = 1'b1;
        if (walkRspValid) begin
          strobe.loadWalk = 1'b1;
          strobe.install  = !walkRspDevice && !walkRspFault;
          stateD          = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tcache_dp.sv
module tcache_dp
  import tcache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 6,
  parameter int SIDES     = 2,
  parameter int CNT_W     = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          invAll,
  input  logic [ADDR_W-1:0]             reqVaddr,
  input  logic                          reqWrite,
  input  logic [$clog2(SIDES)-1:0]      reqSide,
  input  logic [ADDR_W-PAGE_BITS-1:0]   walkRspPage,
  input  logic                          walkRspCow,
  input  logic                          walkRspDevice,
  input  logic                          walkRspFault,
  input  tcStrobe_t                     strobe,
  output logic                          hitRaw,
  output logic                          cowBlock,
  output logic [ADDR_W-1:0]             walkReqVaddr,
  output logic                          walkReqWrite,
  output logic [$clog2(SIDES)-1:0]      walkReqSide,
  output logic                          rspValid,
  output logic [ADDR_W-1:0]             rspPaddr,
  output logic                          rspHit,
  output logic                          rspDevice,
  output logic                          rspFault,
  output logic [CNT_W-1:0]              lookupCount,
  output logic [CNT_W-1:0]              missCount
);

  localparam int VPN_W   = ADDR_W - PAGE_BITS;
  localparam int ENTRIES = 1 << IDX_BITS;
  localparam int SIDE_W  = $clog2(SIDES);

  // captured request
  logic [ADDR_W-1:0] vaQ;
  logic              writeQ;
  logic [SIDE_W-1:0] sideQ;

  logic [VPN_W-1:0]     vpnQ;
  logic [IDX_BITS-1:0]  idxQ;
  logic [PAGE_BITS-1:0] offQ;

  assign vpnQ = vaQ[ADDR_W-1:PAGE_BITS];
  assign idxQ = vaQ[PAGE_BITS +: IDX_BITS];
  assign offQ = vaQ[PAGE_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ    <= '0;
      writeQ <= 1'b0;
      sideQ  <= '0;
    end else if (strobe.latchReq) begin
      vaQ    <= reqVaddr;
      writeQ <= reqWrite;
      sideQ  <= reqSide;
    end
  end

  // translation storage, one table per side
  logic [SIDES-1:0][ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]              tagQ [SIDES][ENTRIES];
  logic [VPN_W-1:0]              ppnQ [SIDES][ENTRIES];
  logic                          cowQ [SIDES][ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN)              validQ <= '0;
    else if (invAll)        validQ <= '0;
    else if (strobe.install) validQ[sideQ][idxQ] <= 1'b1;
  end

  for (genvar s = 0; s < SIDES; s++) begin : gSide
    always_ff @(posedge clk) begin
      if (strobe.install && (sideQ == SIDE_W'(s))) begin
        tagQ[s][idxQ] <= vpnQ;
        ppnQ[s][idxQ] <= walkRspPage;
        cowQ[s][idxQ] <= walkRspCow;
      end
    end
  end

  // lookup of the captured request
  logic             entryValid;
  logic [VPN_W-1:0] entryTag;
  logic [VPN_W-1:0] entryPpn;
  logic             entryCow;

  assign entryValid = validQ[sideQ][idxQ];
  assign entryTag   = tagQ[sideQ][idxQ];
  assign entryPpn   = ppnQ[sideQ][idxQ];
  assign entryCow   = cowQ[sideQ][idxQ];

  assign hitRaw   = entryValid && (entryTag == vpnQ);
  assign cowBlock = writeQ && entryCow;

  assign walkReqVaddr = vaQ;
  assign walkReqWrite = writeQ;
  assign walkReqSide  = sideQ;

  // response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspPaddr  <= '0;
      rspHit    <= 1'b0;
      rspDevice <= 1'b0;
      rspFault  <= 1'b0;
    end else begin
      rspValid  <= strobe.loadHit || strobe.loadWalk;
      rspHit    <= strobe.loadHit;
      rspDevice <= strobe.loadWalk && walkRspDevice;
      rspFault  <= strobe.loadWalk && walkRspFault;
      if (strobe.loadHit)
        rspPaddr <= {entryPpn, offQ};
      else if (strobe.loadWalk)
        rspPaddr <= walkRspFault ? '0 : {walkRspPage, offQ};
    end
  end

  // usage counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookupCount <= '0;
      missCount   <= '0;
    end else begin
      if (strobe.latchReq) lookupCount <= lookupCount + CNT_W'(1);
      if (strobe.incMiss)  missCount   <= missCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/translation_cache.sv
module translation_cache
  import tcache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 6,
  parameter int SIDES     = 2,
  parameter int CNT_W     = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        invAll,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [ADDR_W-1:0]           reqVaddr,
  input  logic                        reqWrite,
  input  logic [$clog2(SIDES)-1:0]    reqSide,
  output logic                        rspValid,
  output logic [ADDR_W-1:0]           rspPaddr,
  output logic                        rspHit,
  output logic                        rspDevice,
  output logic                        rspFault,
  output logic                        walkReqValid,
  output logic [ADDR_W-1:0]           walkReqVaddr,
  output logic                        walkReqWrite,
  output logic [$clog2(SIDES)-1:0]    walkReqSide,
  input  logic                        walkRspValid,
  input  logic [ADDR_W-PAGE_BITS-1:0] walkRspPage,
  input  logic                        walkRspCow,
  input  logic                        walkRspDevice,
  input  logic                        walkRspFault,
  output logic [CNT_W-1:0]            lookupCount,
  output logic [CNT_W-1:0]            missCount
);

  tcStrobe_t strobe;
  logic      hitRaw;
  logic      cowBlock;

  tcache_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .hitRaw       (hitRaw),
    .cowBlock     (cowBlock),
    .walkRspValid (walkRspValid),
    .walkRspDevice(walkRspDevice),
    .walkRspFault (walkRspFault),
    .reqReady     (reqReady),
    .walkReqValid (walkReqValid),
    .strobe       (strobe)
  );

  tcache_dp #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS),
    .IDX_BITS (IDX_BITS),
    .SIDES    (SIDES),
    .CNT_W    (CNT_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .invAll       (invAll),
    .reqVaddr     (reqVaddr),
    .reqWrite     (reqWrite),
    .reqSide      (reqSide),
    .walkRspPage  (walkRspPage),
    .walkRspCow   (walkRspCow),
    .walkRspDevice(walkRspDevice),
    .walkRspFault (walkRspFault),
    .strobe       (strobe),
    .hitRaw       (hitRaw),
    .cowBlock     (cowBlock),
    .walkReqVaddr (walkReqVaddr),
    .walkReqWrite (walkReqWrite),
    .walkReqSide  (walkReqSide),
    .rspValid     (rspValid),
    .rspPaddr     (rspPaddr),
    .rspHit       (rspHit),
    .rspDevice    (rspDevice),
    .rspFault     (rspFault),
    .lookupCount  (lookupCount),
    .missCount    (missCount)
  );

endmodule

// File: rtl/tcache_chk.sv
module tcache_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int CNT_W     = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic              rspHit,
  input logic              rspDevice,
  input logic              rspFault,
  input logic              walkReqValid,
  input logic [ADDR_W-1:0] walkReqVaddr,
  input logic              walkRspValid,
  input logic [CNT_W-1:0]  lookupCount,
  input logic [CNT_W-1:0]  missCount
);

  logic [ADDR_W-1:0] lastVaddr;

  always_ff @(posedge clk) begin
    if (!rstN)                     lastVaddr <= '0;
    else if (reqValid && reqReady) lastVaddr <= reqVaddr;
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    walkReqValid |-> !reqReady); // R2
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (walkReqValid && !walkRspValid) |=> (walkReqValid && $stable(walkReqVaddr))); // R4
  AST_WALK_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    walkReqValid |-> (walkReqVaddr == lastVaddr)); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspPaddr[PAGE_BITS-1:0] == lastVaddr[PAGE_BITS-1:0])); // R3
  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> ($stable(missCount) && !rspDevice && !rspFault)); // R3
  AST_LOOKUP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (lookupCount == $past(lookupCount) + CNT_W'(1))); // R12
  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    missCount <= lookupCount); // R12

endmodule

bind translation_cache tcache_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_BITS(PAGE_BITS),
  .CNT_W    (CNT_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqVaddr    (reqVaddr),
  .rspValid    (rspValid),
  .rspPaddr    (rspPaddr),
  .rspHit      (rspHit),
  .rspDevice   (rspDevice),
  .rspFault    (rspFault),
  .walkReqValid(walkReqValid),
  .walkReqVaddr(walkReqVaddr),
  .walkRspValid(walkRspValid),
  .lookupCount (lookupCount),
  .missCount   (missCount)
);

// File: tb/tb_translation_cache.sv
`timescale 1ns/1ps
module tb_translation_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        invAll = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic [0:0]  reqSide = '0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspHit, rspDevice, rspFault;
  logic        walkReqValid;
  logic [31:0] walkReqVaddr;
  logic        walkReqWrite;
  logic [0:0]  walkReqSide;
  logic        walkRspValid = 1'b0;
  logic [19:0] walkRspPage = '0;
  logic        walkRspCow = 1'b0, walkRspDevice = 1'b0, walkRspFault = 1'b0;
  logic [31:0] lookupCount, missCount;

  always #2 clk = ~clk;

  translation_cache dut (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  int expLookups = 0;
  int expMisses  = 0;
  logic [19:0] serial = 20'h00101;

  // reference tables
  bit          mValid [2][64];
  logic [19:0] mVpn   [2][64];
  logic [19:0] mPpn   [2][64];
  bit          mCow   [2][64];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] walkPage(input logic [19:0] vpn);
    return vpn ^ serial;
  endfunction

  function automatic bit predictHit(input int side, input logic [31:0] va, input bit wr);
    int idx = int'(va[17:12]);
    return mValid[side][idx] && (mVpn[side][idx] == va[31:12]) && !(wr && mCow[side][idx]);
  endfunction

  task automatic doAccess(input int side, input logic [31:0] va, input bit wr,
                          input bit cow, input bit dev, input bit flt,
                          input string req, input int dly);
    int idx = int'(va[17:12]);
    bit expHit = predictHit(side, va, wr);
    logic [19:0] pg;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqSide = side[0:0];
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    expLookups++;
    check(!rspValid && !reqReady, req, "busy after accept", {30'd0, rspValid, reqReady}, 32'd0);
    @(negedge clk);
    if (expHit) begin
      check(rspValid && rspHit && !walkReqValid, req, "hit response",
            {29'd0, rspValid, rspHit, walkReqValid}, 32'd6);
      check(rspPaddr == {mPpn[side][idx], va[11:0]}, req, "hit paddr",
            rspPaddr, {mPpn[side][idx], va[11:0]});
    end else begin
      expMisses++;
      check(walkReqValid && !rspValid, req, "walk request", {30'd0, walkReqValid, rspValid}, 32'd2);
      check(walkReqVaddr == va && walkReqWrite == wr && walkReqSide == side[0:0], req,
            "walk fields", walkReqVaddr, va);
      for (int d = 0; d < dly; d++) @(negedge clk);
      check(walkReqValid && !reqReady, "R4", "walk held", {30'd0, walkReqValid, reqReady}, 32'd2);
      pg = walkPage(va[31:12]);
      serial = serial + 20'h00337;
      walkRspValid = 1'b1; walkRspPage = pg;
      walkRspCow = cow; walkRspDevice = dev; walkRspFault = flt;
      @(negedge clk);
      walkRspValid = 1'b0; walkRspCow = 1'b0; walkRspDevice = 1'b0; walkRspFault = 1'b0;
      check(rspValid && !rspHit && rspDevice == dev && rspFault == flt, req, "walk response",
            {28'd0, rspValid, rspHit, rspDevice, rspFault}, {28'd0, 1'b1, 1'b0, dev, flt});
      check(rspPaddr == (flt ? 32'd0 : {pg, va[11:0]}), req, "walk paddr",
            rspPaddr, flt ? 32'd0 : {pg, va[11:0]});
      if (!dev && !flt) begin
        mValid[side][idx] = 1'b1; mVpn[side][idx] = va[31:12];
        mPpn[side][idx] = pg;     mCow[side][idx] = cow;
      end
    end
    check(reqReady, "R2", "ready after response", {31'd0, reqReady}, 32'd1);
    check(lookupCount == expLookups, "R12", "lookup count", lookupCount, expLookups);
    check(missCount == expMisses, "R12", "miss count", missCount, expMisses);
    @(negedge clk);
    check(!rspValid, "R2", "single response pulse", {31'd0, rspValid}, 32'd0);
  endtask

  task automatic invalidate();
    @(negedge clk);
    invAll = 1'b1;
    @(negedge clk);
    invAll = 1'b0;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 64; i++) mValid[s][i] = 1'b0;
  endtask

  task automatic expectHit(input int side, input logic [31:0] va, input bit wr,
                           input bit want, input string req);
    check(predictHit(side, va, wr) == want, req, "model expectation",
          {31'd0, predictHit(side, va, wr)}, {31'd0, want});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady && !rspValid && !walkReqValid, "R1", "reset outputs",
          {29'd0, reqReady, rspValid, walkReqValid}, 32'd4);
    check(lookupCount == 0 && missCount == 0, "R1", "reset counters", lookupCount | missCount, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: first access after reset misses; R5 install then hit
    doAccess(1, 32'h1234_5678, 0, 0, 0, 0, "R1", 0);
    expectHit(1, 32'h1234_5ABC, 0, 1, "R5");
    doAccess(1, 32'h1234_5ABC, 0, 0, 0, 0, "R5", 0);
    doAccess(1, 32'h1234_5004, 1, 0, 0, 0, "R3", 0);
    // R6: other side misses
    doAccess(0, 32'h1234_5678, 0, 0, 0, 0, "R6", 2);
    doAccess(0, 32'h1234_5010, 0, 0, 0, 0, "R3", 0);
    // R7: conflicting page at same index
    doAccess(1, 32'h7FF4_5020, 0, 0, 0, 0, "R7", 1);
    expectHit(1, 32'h1234_5678, 0, 0, "R7");
    doAccess(1, 32'h1234_5678, 0, 0, 0, 0, "R7", 0);
    // R8 copy-on-write
    doAccess(1, 32'h0000_9100, 0, 1, 0, 0, "R8", 0);
    doAccess(1, 32'h0000_9104, 0, 0, 0, 0, "R8", 0);
    expectHit(1, 32'h0000_9108, 1, 0, "R8");
    doAccess(1, 32'h0000_9108, 1, 0, 0, 0, "R8", 3);
    doAccess(1, 32'h0000_910C, 1, 0, 0, 0, "R8", 0);
    // R9 device-backed
    doAccess(0, 32'hC003_A000, 0, 0, 1, 0, "R9", 0);
    doAccess(0, 32'hC003_A004, 0, 0, 0, 0, "R9", 0);
    // R10 fault
    doAccess(1, 32'hDEAD_BEEF, 1, 0, 0, 1, "R10", 1);
    doAccess(1, 32'hDEAD_BEE0, 0, 0, 0, 0, "R10", 0);
    // R11 invalidate everything
    invalidate();
    doAccess(0, 32'h1234_5678, 0, 0, 0, 0, "R11", 0);
    doAccess(1, 32'h0000_9100, 0, 0, 0, 0, "R11", 0);
    doAccess(1, 32'h0000_9100, 0, 0, 0, 0, "R3", 0);

    // random traffic from a small page pool
    for (int n = 0; n < 400; n++) begin
      logic [13:0] hiPool [4] = '{14'h0004, 14'h048D, 14'h3FFF, 14'h0000};
      logic [31:0] va = {hiPool[$urandom_range(3)], 3'b000, 3'($urandom_range(7)),
                         12'($urandom)};
      int r = int'($urandom_range(15));
      if (r == 0) invalidate();
      doAccess(int'($urandom_range(1)), va, bit'($urandom_range(1)),
               ($urandom_range(3) == 0), ($urandom_range(9) == 0),
               ($urandom_range(11) == 0), "R3", int'($urandom_range(3)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule